// File: doc/BRIEF.md
# Protected Cipher Mode Configuration Register

This block is the 32-bit mode register of a block-cipher accelerator. It sits on a simple memory-mapped bus: address, write enable, write data, and a registered read data path. It decodes the stored word into the fields the rest of the engine uses. These are the chaining mode, key length, start policy, processing delay, dual input buffering, automatic tag generation, cipher direction, cipher-feedback segment size and the tamper wipe policy.

Two checks guard writes. While the external lock input is high, every write is ignored. The very first accepted write after reset must also carry the unlock nibble 0xE in bits 23:20. Once that write has landed, the register is armed, and later writes go through whatever those bits hold. The unlock nibble is never stored and always reads back as zero.

A tamper event input drives a key-wipe output in the same cycle, but only when the tamper wipe bit of the register is set.

Top module: `cmode_cfg_reg`

## Requirements
- R1: After reset the register reads 0x00080000 and every decoded field output is zero.
- R2: While `wr_lock` is 1, a write to the register leaves its contents and field outputs unchanged.
- R3: Before the register is armed, a write whose bits 23:20 differ from 0xE is dropped completely and leaves the register unarmed. A write carrying 0xE there is accepted and arms it.
- R4: Once armed, a write is accepted for any value of bits 23:20.
- R5: Bits 23:20 always read as 0.
- R6: Bits 30:24 and bit 2 read as 0 and ignore writes. Bit 19 is read-only and always reads 1. Every other bit reads back the last accepted write.
- R7: The field outputs follow the stored bits. The assignments are:
  - `tamper_clr` is bit 31.
  - `fb_size` is bits 18:16, with 0..4 meaning 128/64/32/16/8-bit segments.
  - `last_out` is bit 15.
  - `op_mode` is bits 14:12, with 0 ECB, 1 CBC, 2 OFB, 3 CFB, 4 CTR, 5 GCM and 6 XTS.
  - `key_size` is bits 11:10, with 0/1/2 meaning 128/192/256.
  - `start_mode` is bits 9:8.
  - `proc_dly` is bits 7:4.
  - `dual_buf` is bit 3.
  - `tag_en` is bit 1.
  - `encrypt` is bit 0, where 1 means encrypt.
  The field outputs change on the clock edge that accepts the write.
- R8: `key_wipe` is high in the same cycle as `tamper_evt` when bit 31 is 1. It stays low when bit 31 is 0.
- R9: The armed state clears only on reset. After a reset, the unlock nibble is required again.
- R10: Only address `REG_OFS` (default 0x04) is decoded. Writes to other addresses are ignored. A read returns the register value, or 0 for other addresses, on `bus_rdata` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered read data |
| wr_lock | input | 1 | External write-protect enable |
| tamper_evt | input | 1 | Tamper detection pulse |
| key_wipe | output | 1 | Key-clear request |
| tamper_clr | output | 1 | Tamper wipe policy bit |
| fb_size | output | 3 | Cipher-feedback segment size code |
| last_out | output | 1 | Last-output data mode |
| op_mode | output | 3 | Chaining mode code |
| key_size | output | 2 | Key length code |
| start_mode | output | 2 | Start policy code |
| proc_dly | output | 4 | Processing delay |
| dual_buf | output | 1 | Dual input buffer enable |
| tag_en | output | 1 | Automatic tag generation enable |
| encrypt | output | 1 | Direction, 1 = encrypt |

## Verification
The unarmed register is hit with first writes carrying each of the fifteen wrong unlock nibbles. This separates an exact 0xE compare from a partial or masked one. It also shows that a rejected write leaves no partial update and no arming behind.

Once armed, all sixteen nibble values are written with pseudo-random payloads. Comparing the readback against the mask-computed word and every field slice shows whether bits are misplaced, reserved bits leak, or bit 19 is lost.

Locked writes, writes to a wrong address, tamper pulses under both policy values, and a reset that must re-demand the nibble cover the remaining gating paths.

// File: rtl/cmode_cfg_pkg.sv
package cmode_cfg_pkg;

  localparam int unsigned WORD_W = 32;

  // unlock nibble and its position
  localparam logic [3:0] UNLOCK_KEY = 4'hE;
  localparam int unsigned KEY_LO    = 20;
  localparam int unsigned KEY_W     = 4;

  // bits held in storage, and the read-only one
  localparam logic [WORD_W-1:0] STORE_MASK = 32'h8007_FFFB;
  localparam logic [WORD_W-1:0] FIXED_ONES = 32'h0008_0000;

  // field positions
  localparam int unsigned TCLR_B   = 31;
  localparam int unsigned FBS_LO   = 16;
  localparam int unsigned LOD_B    = 15;
  localparam int unsigned OPM_LO   = 12;
  localparam int unsigned KSZ_LO   = 10;
  localparam int unsigned SMD_LO   = 8;
  localparam int unsigned DLY_LO   = 4;
  localparam int unsigned DBUF_B   = 3;
  localparam int unsigned TAG_B    = 1;
  localparam int unsigned ENC_B    = 0;

  typedef enum logic [2:0] {
    CHAIN_ECB = 3'd0,
    CHAIN_CBC = 3'd1,
    CHAIN_OFB = 3'd2,
    CHAIN_CFB = 3'd3,
    CHAIN_CTR = 3'd4,
    CHAIN_GCM = 3'd5,
    CHAIN_XTS = 3'd6
  } chain_mode_e;

  typedef struct packed {
    logic        tamper_clr;
    logic [2:0]  fb_size;
    logic        last_out;
    chain_mode_e op_mode;
    logic [1:0]  key_size;
    logic [1:0]  start_mode;
    logic [3:0]  proc_dly;
    logic        dual_buf;
    logic        tag_en;
    logic        encrypt;
  } cfg_fields_t;

endpackage

// File: rtl/cmode_cfg_wgate.sv
module cmode_cfg_wgate
  import cmode_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_we,
  input  logic             wr_lock,
  input  logic [KEY_W-1:0] key_nib,
  output logic             accept,
  output logic             armed
);

  logic key_ok;

  assign key_ok = (key_nib == UNLOCK_KEY);
  assign accept = hit_we && !wr_lock && (armed || key_ok);

  always_ff @(posedge clk) begin
    if (rst)         armed <= 1'b0;
    else if (accept) armed <= 1'b1;
  end

  // R3: an unarmed write without the unlock nibble leaves it unarmed
  a_r3_first_needs_key: assert property (@(posedge clk) disable iff (rst)
    (!armed && hit_we && (key_nib != UNLOCK_KEY)) |-> !accept);

  a_r3_unarmed_hold: assert property (@(posedge clk) disable iff (rst)
    (!armed && !accept) |=> !armed);

  // R9: once armed, stays armed until reset
  a_r9_armed_sticky: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

  // R2: locked writes never pass the gate
  a_r2_lock_blocks: assert property (@(posedge clk) disable iff (rst)
    wr_lock |-> !accept);

endmodule

// File: rtl/cmode_cfg_store.sv
module cmode_cfg_store
  import cmode_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word_q,
  output cfg_fields_t       fields
);

  logic [WORD_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (accept) q <= wdata & STORE_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fields <= '0;
    end else if (accept) begin
      fields.tamper_clr <= wdata[TCLR_B];
      fields.fb_size    <= wdata[FBS_LO +: 3];
      fields.last_out   <= wdata[LOD_B];
      fields.op_mode    <= chain_mode_e'(wdata[OPM_LO +: 3]);
      fields.key_size   <= wdata[KSZ_LO +: 2];
      fields.start_mode <= wdata[SMD_LO +: 2];
      fields.proc_dly   <= wdata[DLY_LO +: 4];
      fields.dual_buf   <= wdata[DBUF_B];
      fields.tag_en     <= wdata[TAG_B];
      fields.encrypt    <= wdata[ENC_B];
    end
  end

  assign word_q = q | FIXED_ONES;

  // R1: first cycle after reset holds the reset image
  a_r1_reset_image: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (word_q == FIXED_ONES && fields == '0));

  // R7: decoded fields agree with the stored word
  a_r7_fields_match: assert property (@(posedge clk) disable iff (rst)
    (fields.tamper_clr == word_q[TCLR_B]) &&
    (fields.op_mode == chain_mode_e'(word_q[OPM_LO +: 3])) &&
    (fields.encrypt == word_q[ENC_B]));

  // R6: reserved bits never become set
  a_r6_reserved_clear: assert property (@(posedge clk) disable iff (rst)
    (word_q[30:24] == '0) && !word_q[2] && word_q[19]);

endmodule

// File: rtl/cmode_cfg_rdport.sv
module cmode_cfg_rdport
  import cmode_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h04
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] word_q,
  output logic [WORD_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst)                  rdata <= '0;
    else if (addr == REG_OFS) rdata <= word_q;
    else                      rdata <= '0;
  end

  // R5: unlock nibble never visible
  a_r5_key_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[KEY_LO +: KEY_W] == '0);

  // R10: other addresses read zero
  a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (addr != REG_OFS) |=> (rdata == '0));

endmodule

// File: rtl/cmode_cfg_reg.sv
module cmode_cfg_reg
  import cmode_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h04
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wr_lock,
  input  logic              tamper_evt,
  output logic              key_wipe,
  output logic              tamper_clr,
  output logic [2:0]        fb_size,
  output logic              last_out,
  output logic [2:0]        op_mode,
  output logic [1:0]        key_size,
  output logic [1:0]        start_mode,
  output logic [3:0]        proc_dly,
  output logic              dual_buf,
  output logic              tag_en,
  output logic              encrypt
);

  logic              hit_we;
  logic              accept;
  logic              armed;
  logic [WORD_W-1:0] word_q;
  cfg_fields_t       fields;

  assign hit_we = bus_we && (bus_addr == REG_OFS);

  cmode_cfg_wgate u_gate (
    .clk     (clk),
    .rst     (rst),
    .hit_we  (hit_we),
    .wr_lock (wr_lock),
    .key_nib (bus_wdata[KEY_LO +: KEY_W]),
    .accept  (accept),
    .armed   (armed)
  );

  cmode_cfg_store u_store (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .wdata  (bus_wdata),
    .word_q (word_q),
    .fields (fields)
  );

  cmode_cfg_rdport #(
    .ADDR_W  (ADDR_W),
    .REG_OFS (REG_OFS)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .word_q (word_q),
    .rdata  (bus_rdata)
  );

  assign key_wipe   = tamper_evt && fields.tamper_clr;

  assign tamper_clr = fields.tamper_clr;
  assign fb_size    = fields.fb_size;
  assign last_out   = fields.last_out;
  assign op_mode    = fields.op_mode;
  assign key_size   = fields.key_size;
  assign start_mode = fields.start_mode;
  assign proc_dly   = fields.proc_dly;
  assign dual_buf   = fields.dual_buf;
  assign tag_en     = fields.tag_en;
  assign encrypt    = fields.encrypt;

  // R2: locked write leaves the stored word unchanged
  a_r2_lock_stable: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && bus_we) |=> $stable(word_q));

  // R8: wipe follows the tamper policy bit of the stored word
  a_r8_wipe_policy: assert property (@(posedge clk) disable iff (rst)
    key_wipe == (tamper_evt && word_q[TCLR_B]));

  // R10: a write elsewhere changes nothing
  a_r10_miss_no_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr != REG_OFS) |=> $stable(word_q));

endmodule

// File: tb/cmode_cfg_reg_test.sv
module cmode_cfg_reg_test;

  localparam logic [7:0]  OFS   = 8'h04;
  localparam logic [31:0] SMASK = 32'h8007_FFFB;
  localparam logic [31:0] ONES  = 32'h0008_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wr_lock = 1'b0;
  logic        tamper_evt = 1'b0;
  logic        key_wipe, tamper_clr, last_out, dual_buf, tag_en, encrypt;
  logic [2:0]  fb_size, op_mode;
  logic [1:0]  key_size, start_mode;
  logic [3:0]  proc_dly;

  int total = 0;
  int bad   = 0;
  logic [31:0] lcg = 32'h1234_5678;
  logic [31:0] cur;

  always #5 clk = ~clk;

  cmode_cfg_reg uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_lock(wr_lock),
    .tamper_evt(tamper_evt), .key_wipe(key_wipe), .tamper_clr(tamper_clr),
    .fb_size(fb_size), .last_out(last_out), .op_mode(op_mode),
    .key_size(key_size), .start_mode(start_mode), .proc_dly(proc_dly),
    .dual_buf(dual_buf), .tag_en(tag_en), .encrypt(encrypt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    lcg = lcg * 32'h0019_660D + 32'h3C6E_F35F;
    return lcg;
  endfunction

  function automatic logic [31:0] pack_fields();
    return {tamper_clr, 12'd0, fb_size, last_out, op_mode, key_size,
            start_mode, proc_dly, dual_buf, 1'b0, tag_en, encrypt};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic lk);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d; wr_lock = lk;
    @(negedge clk);
    bus_we = 1'b0; wr_lock = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin : watchdog
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] r, d, e;
    do_reset();
    // R1 reset image
    rd(OFS, r);
    check("R1 reset read", r, 32'h0008_0000);
    check("R1 fields zero", pack_fields() | {31'd0, key_wipe}, 32'h0);

    // R3 every wrong nibble on first write
    for (int n = 0; n < 16; n++) begin
      if (n == 14) continue;
      d = nxt();
      d[23:20] = 4'(n);
      wr(OFS, d, 1'b0);
      rd(OFS, r);
      check("R3 wrong key dropped", r, ONES);
    end
    // R2 locked write with correct key
    d = nxt(); d[23:20] = 4'hE;
    wr(OFS, d, 1'b1);
    rd(OFS, r);
    check("R2 locked unarmed", r, ONES);

    // R3 correct key arms
    d = 32'hFFFF_FFFF;
    d[23:20] = 4'hE;
    wr(OFS, d, 1'b0);
    rd(OFS, r);
    check("R3 key accepted R6 mask", r, SMASK | ONES);
    check("R7 fields all ones", pack_fields(), SMASK & 32'h8007_FFFB & ~32'h0);

    // R4 R5 R6 R7 armed sweep of all nibbles
    for (int n = 0; n < 16; n++) begin
      d = nxt();
      d[23:20] = 4'(n);
      wr(OFS, d, 1'b0);
      e = (d & SMASK) | ONES;
      check("R7 fields", pack_fields(), d & SMASK);
      rd(OFS, r);
      check("R4 R5 R6 readback", r, e);
    end
    cur = e;

    // R2 locked when armed
    wr(OFS, ~cur, 1'b1);
    rd(OFS, r);
    check("R2 locked armed", r, cur);

    // R10 other address
    wr(8'h08, ~cur, 1'b0);
    rd(OFS, r);
    check("R10 miss write ignored", r, cur);
    rd(8'h08, r);
    check("R10 miss read zero", r, 32'h0);

    // R8 tamper policy off then on
    wr(OFS, 32'h0000_1234, 1'b0);
    @(negedge clk); tamper_evt = 1'b1; #1;
    check("R8 no wipe when clear", {31'd0, key_wipe}, 32'd0);
    @(negedge clk); tamper_evt = 1'b0;
    wr(OFS, 32'h8000_1234, 1'b0);
    #1 check("R8 idle no wipe", {31'd0, key_wipe}, 32'd0);
    @(negedge clk); tamper_evt = 1'b1; #1;
    check("R8 wipe same cycle", {31'd0, key_wipe}, 32'd1);
    @(negedge clk); tamper_evt = 1'b0; #1;
    check("R8 wipe released", {31'd0, key_wipe}, 32'd0);

    // R9 reset disarms
    do_reset();
    rd(OFS, r);
    check("R1 reset again", r, ONES);
    wr(OFS, 32'h0000_00FF, 1'b0);
    rd(OFS, r);
    check("R9 key needed again", r, ONES);
    wr(OFS, 32'h00E0_00FF, 1'b0);
    rd(OFS, r);
    check("R9 rearmed", r, 32'h0008_00FB);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule